// File: doc/BRIEF.md
# Configuration-Port Streaming Bridge

This block is a peripheral-bus slave (APB handshake) that lets a processor move configuration words into a slow internal configuration port and read words back out of it. Software fills an on-chip buffer through a data window register, programs a word count, and then issues a start command. The block then moves the buffer contents to the configuration port one word at a time. Readback works the other way round: the block collects words from the port into the same buffer, and software drains them through the data window.

The design has three parts. A bus decoder turns each completed bus access into either a command (start write, start readback, clear pointers, clear flags) or a payload word for the buffer. A buffer controller owns a two-port memory and the bus-side write and read pointers. A port sequencer moves words between the buffer and the configuration port. Every bus access takes a fixed number of access-phase cycles, so a processor always sees the same wait-state pattern. Transfers must cover whole 41-word frames.

The bus decoder has three states. `BUS_IDLE` moves to `BUS_WAIT` on the first access-phase cycle. `BUS_WAIT` counts wait cycles and moves to `BUS_READY`. `BUS_READY` raises the ready signal and returns to `BUS_IDLE`. The port sequencer has five states:
- `PC_IDLE` moves to `PC_WR_FETCH` on an accepted write start, or to `PC_RD_XFER` on an accepted readback start.
- `PC_WR_FETCH` reads the buffer and moves to `PC_WR_XFER`.
- `PC_WR_XFER` holds a port write for four cycles. It then returns to `PC_WR_FETCH`, or to `PC_IDLE` after the last word.
- `PC_RD_XFER` holds a port read for four cycles and then moves to `PC_RD_STORE`.
- `PC_RD_STORE` writes the captured word to the buffer. It then returns to `PC_RD_XFER`, or to `PC_IDLE` after the last word.

Top module: `cfgport_apb_bridge`

## Requirements
- R1: After reset, `pready` and `cfg_en` are low, and the STATUS and COUNT registers read 0.
- R2: Every bus access has a fixed length. `pready` is low during the first three access-phase cycles and high in the fourth, and it is never high outside an access phase.
- R3: Register selection uses `paddr[3:2]`: 0 is CTRL, 1 is STATUS, 2 is COUNT and 3 is DATA. When idle, a write to DATA stores the word at the bus write pointer and advances that pointer. Writing CTRL bit 2 returns both bus pointers to buffer address 0.
- R4: Writing CTRL bit 0 with a valid count starts a write transfer. Busy goes high, buffer words 0 to count-1 are sent to the port in address order, and then busy clears and done sets.
- R5: Writing CTRL bit 1 with a valid count starts a readback. The block reads count words from the port and stores them at buffer addresses 0 upward, and the bus read pointer rewinds to 0. Successive DATA reads then return those words in arrival order.
- R6: Each port transaction holds `cfg_en` high for exactly four consecutive cycles, with `cfg_we` and `cfg_wdata` stable throughout. Read data is taken from `cfg_rdata` in the fourth cycle, and at least one idle cycle separates transactions.
- R7: A start is refused if the count is zero, not a multiple of 41, or larger than the buffer depth (128). In that case no port transaction occurs, busy stays low and the error flag sets.
- R8: A DATA write while busy completes with `pslverr` high and sets the refused flag. The buffer contents and the write pointer stay unchanged.
- R9: STATUS bit 0 is busy, bit 1 is done, bit 2 is error and bit 3 is refused. Writing CTRL bit 3 clears done, error and refused. An accepted start clears done and error.
- R10: A start command that arrives while busy is ignored. If bits 0 and 1 are written together, the write transfer wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase marker |
| pwrite | input | 1 | 1 for write, 0 for read |
| paddr | input | 4 | Byte address; bits 3:2 select the register |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data, valid with pready |
| pready | output | 1 | Access completes this cycle |
| pslverr | output | 1 | Refused DATA write |
| cfg_en | output | 1 | Port transaction active |
| cfg_we | output | 1 | Port transaction is a write |
| cfg_wdata | output | 32 | Word sent to the port |
| cfg_rdata | input | 32 | Word returned by the port |

## Verification
The bench pushes a DATA write into the middle of a running transfer. It then sends a second, longer transfer that must show the old words followed by the new ones. A design that stored the refused word, or advanced the pointer anyway, would send a shifted or corrupted stream. Counts of 40, 0 and 164 must leave the port silent; a design with a loose frame check would start a transfer and run past its frame boundary. The bench also issues a readback start during a write transfer and a combined start of both kinds; a wrong priority or a missing busy guard would show up as port reads. Finally, a clock-by-clock model of ready timing and port pulse width catches a wait count that is one cycle off and data that changes in the middle of a transaction.

// File: rtl/cfgbr_pkg.sv
package cfgbr_pkg;

    // register select, taken from paddr[3:2]
    typedef enum logic [1:0] {
        SEL_CTRL  = 2'd0,
        SEL_STAT  = 2'd1,
        SEL_COUNT = 2'd2,
        SEL_DATA  = 2'd3
    } reg_sel_e;

    typedef enum logic [1:0] {
        BUS_IDLE,
        BUS_WAIT,
        BUS_READY
    } bus_state_e;

    typedef enum logic [2:0] {
        PC_IDLE,
        PC_WR_FETCH,
        PC_WR_XFER,
        PC_RD_XFER,
        PC_RD_STORE
    } pc_state_e;

    // CTRL bit positions
    localparam int CTRL_WR_BIT   = 0;
    localparam int CTRL_RD_BIT   = 1;
    localparam int CTRL_PTR_BIT  = 2;
    localparam int CTRL_FLAG_BIT = 3;

endpackage

// File: rtl/cfgbr_apb_dec.sv
module cfgbr_apb_dec
    import cfgbr_pkg::*;
#(
    parameter int DW    = 32,
    parameter int AW    = 4,
    parameter int DEPTH = 128,
    parameter int FRAME = 41,
    parameter int ACC   = 4,    // access-phase cycles per bus access, >= 3
    parameter int CNT_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [AW-1:0]    paddr,
    input  logic [DW-1:0]    pwdata,
    output logic [DW-1:0]    prdata,
    output logic             pready,
    output logic             pslverr,
    input  logic             busy_i,
    input  logic             done_i,
    input  logic [DW-1:0]    buf_rdata_i,
    output logic             push_o,
    output logic             pop_o,
    output logic             clr_ptr_o,
    output logic             clr_done_o,
    output logic             go_wr_o,
    output logic             go_rd_o,
    output logic [CNT_W-1:0] len_o
);

    localparam int WCW = $clog2(ACC);

    bus_state_e       state_q, state_d;
    logic [WCW-1:0]   wcnt_q, wcnt_d;
    logic [CNT_W-1:0] count_q;
    logic             err_q, refused_q;
    logic             fire, wr_ctrl, start_req, count_ok;
    reg_sel_e         sel;

    assign sel = reg_sel_e'(paddr[3:2]);

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= BUS_IDLE;
            wcnt_q  <= '0;
        end else begin
            state_q <= state_d;
            wcnt_q  <= wcnt_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        wcnt_d  = wcnt_q;
        unique case (state_q)
            BUS_IDLE: begin
                if (psel && penable) begin
                    state_d = BUS_WAIT;
                    wcnt_d  = WCW'(1);
                end
            end
            BUS_WAIT: begin
                if (!(psel && penable))
                    state_d = BUS_IDLE;
                else if (wcnt_q == WCW'(ACC - 2))
                    state_d = BUS_READY;
                else
                    wcnt_d = wcnt_q + WCW'(1);
            end
            BUS_READY: state_d = BUS_IDLE;
            default:   state_d = BUS_IDLE;
        endcase
    end

    // outputs and strobes
    always_comb begin
        pready     = (state_q == BUS_READY);
        fire       = pready && psel && penable;
        count_ok   = (count_q != '0) && (count_q <= CNT_W'(DEPTH))
                     && ((int'(count_q) % FRAME) == 0);
        wr_ctrl    = fire && pwrite && (sel == SEL_CTRL);
        start_req  = wr_ctrl && (pwdata[CTRL_WR_BIT] || pwdata[CTRL_RD_BIT]) && !busy_i;
        go_wr_o    = start_req && count_ok && pwdata[CTRL_WR_BIT];
        go_rd_o    = start_req && count_ok && !pwdata[CTRL_WR_BIT];
        clr_ptr_o  = wr_ctrl && pwdata[CTRL_PTR_BIT];
        clr_done_o = wr_ctrl && pwdata[CTRL_FLAG_BIT];
        push_o     = fire && pwrite && (sel == SEL_DATA) && !busy_i;
        pop_o      = fire && !pwrite && (sel == SEL_DATA);
        pslverr    = pready && pwrite && (sel == SEL_DATA) && busy_i;
        len_o      = count_q;
        unique case (sel)
            SEL_CTRL:  prdata = '0;
            SEL_STAT:  prdata = DW'({refused_q, err_q, done_i, busy_i});
            SEL_COUNT: prdata = DW'(count_q);
            SEL_DATA:  prdata = buf_rdata_i;
            default:   prdata = '0;
        endcase
    end

    // register bank
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count_q   <= '0;
            err_q     <= 1'b0;
            refused_q <= 1'b0;
        end else begin
            if (fire && pwrite && (sel == SEL_COUNT))
                count_q <= pwdata[CNT_W-1:0];
            if (clr_done_o) begin
                err_q     <= 1'b0;
                refused_q <= 1'b0;
            end
            if (start_req)
                err_q <= !count_ok;
            if (fire && pwrite && (sel == SEL_DATA) && busy_i)
                refused_q <= 1'b1;
        end
    end

    assert_ready_in_access_R2: assert property (@(posedge clk) disable iff (!rst_n)
        pready |-> (psel && penable));

    assert_ready_after_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pready) |-> $past(psel && penable));

endmodule

// File: rtl/cfgbr_buf.sv
module cfgbr_buf #(
    parameter int DW    = 32,
    parameter int DEPTH = 128,
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push_i,
    input  logic [DW-1:0]    push_data_i,
    input  logic             pop_i,
    input  logic             clr_ptr_i,
    input  logic             rewind_rd_i,
    input  logic             busy_i,
    output logic [DW-1:0]    bus_rdata_o,
    input  logic [PTR_W-1:0] pb_addr_i,
    input  logic             pb_we_i,
    input  logic [DW-1:0]    pb_wdata_i,
    output logic [DW-1:0]    pb_rdata_o
);

    logic [DW-1:0]    mem [DEPTH];
    logic [PTR_W-1:0] bw_q, br_q;

    // two-port storage: bus side and port side
    always_ff @(posedge clk) begin
        if (push_i)
            mem[bw_q] <= push_data_i;
        if (pb_we_i)
            mem[pb_addr_i] <= pb_wdata_i;
        bus_rdata_o <= mem[br_q];
        pb_rdata_o  <= mem[pb_addr_i];
    end

    // bus-side pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bw_q <= '0;
            br_q <= '0;
        end else if (clr_ptr_i) begin
            bw_q <= '0;
            br_q <= '0;
        end else begin
            if (push_i)
                bw_q <= bw_q + PTR_W'(1);
            if (rewind_rd_i)
                br_q <= '0;
            else if (pop_i)
                br_q <= br_q + PTR_W'(1);
        end
    end

    assert_no_push_busy_R8: assert property (@(posedge clk) disable iff (!rst_n)
        push_i |-> !busy_i);

    assert_port_write_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
        pb_we_i |-> busy_i);

endmodule

// File: rtl/cfgbr_portctl.sv
module cfgbr_portctl
    import cfgbr_pkg::*;
#(
    parameter int DW    = 32,
    parameter int DEPTH = 128,
    parameter int FRAME = 41,
    parameter int ACC   = 4,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int PTR_W = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go_wr_i,
    input  logic             go_rd_i,
    input  logic [CNT_W-1:0] len_i,
    input  logic             clr_done_i,
    output logic             busy_o,
    output logic             done_o,
    output logic [PTR_W-1:0] pb_addr_o,
    output logic             pb_we_o,
    output logic [DW-1:0]    pb_wdata_o,
    input  logic [DW-1:0]    pb_rdata_i,
    output logic             cfg_en_o,
    output logic             cfg_we_o,
    output logic [DW-1:0]    cfg_wdata_o,
    input  logic [DW-1:0]    cfg_rdata_i
);

    localparam int ACW = (ACC > 1) ? $clog2(ACC) : 1;

    pc_state_e        state_q, state_d;
    logic [CNT_W-1:0] idx_q, idx_d, len_q, len_d;
    logic [ACW-1:0]   acnt_q, acnt_d;
    logic [DW-1:0]    rhold_q, rhold_d;
    logic             done_q, done_d;
    logic             beat_last, word_last;

    assign beat_last = (acnt_q == ACW'(ACC - 1));
    assign word_last = (idx_q == len_q - CNT_W'(1));

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= PC_IDLE;
            idx_q   <= '0;
            len_q   <= '0;
            acnt_q  <= '0;
            rhold_q <= '0;
            done_q  <= 1'b0;
        end else begin
            state_q <= state_d;
            idx_q   <= idx_d;
            len_q   <= len_d;
            acnt_q  <= acnt_d;
            rhold_q <= rhold_d;
            done_q  <= done_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        idx_d   = idx_q;
        len_d   = len_q;
        acnt_d  = acnt_q;
        rhold_d = rhold_q;
        done_d  = clr_done_i ? 1'b0 : done_q;
        unique case (state_q)
            PC_IDLE: begin
                if (go_wr_i) begin
                    state_d = PC_WR_FETCH;
                    idx_d   = '0;
                    len_d   = len_i;
                    done_d  = 1'b0;
                end else if (go_rd_i) begin
                    state_d = PC_RD_XFER;
                    idx_d   = '0;
                    len_d   = len_i;
                    acnt_d  = '0;
                    done_d  = 1'b0;
                end
            end
            PC_WR_FETCH: begin
                state_d = PC_WR_XFER;
                acnt_d  = '0;
            end
            PC_WR_XFER: begin
                if (!beat_last)
                    acnt_d = acnt_q + ACW'(1);
                else if (word_last) begin
                    state_d = PC_IDLE;
                    done_d  = 1'b1;
                end else begin
                    idx_d   = idx_q + CNT_W'(1);
                    state_d = PC_WR_FETCH;
                end
            end
            PC_RD_XFER: begin
                if (!beat_last)
                    acnt_d = acnt_q + ACW'(1);
                else begin
                    rhold_d = cfg_rdata_i;
                    state_d = PC_RD_STORE;
                end
            end
            PC_RD_STORE: begin
                if (word_last) begin
                    state_d = PC_IDLE;
                    done_d  = 1'b1;
                end else begin
                    idx_d   = idx_q + CNT_W'(1);
                    acnt_d  = '0;
                    state_d = PC_RD_XFER;
                end
            end
            default: state_d = PC_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        busy_o      = (state_q != PC_IDLE);
        done_o      = done_q;
        cfg_en_o    = (state_q == PC_WR_XFER) || (state_q == PC_RD_XFER);
        cfg_we_o    = (state_q == PC_WR_XFER);
        cfg_wdata_o = (state_q == PC_WR_XFER) ? pb_rdata_i : '0;
        pb_addr_o   = idx_q[PTR_W-1:0];
        pb_we_o     = (state_q == PC_RD_STORE);
        pb_wdata_o  = rhold_q;
    end

    assert_beat_stable_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_o && acnt_q != '0) |-> ($past(cfg_en_o) && $stable(cfg_we_o) && $stable(cfg_wdata_o)));

    assert_beat_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en_o && beat_last) |=> !cfg_en_o);

    assert_len_frames_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |-> (len_q != '0 && (int'(len_q) % FRAME) == 0 && len_q <= CNT_W'(DEPTH)));

    assert_done_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !busy_o);

endmodule

// File: rtl/cfgport_apb_bridge.sv
module cfgport_apb_bridge #(
    parameter int DW          = 32,
    parameter int AW          = 4,
    parameter int DEPTH       = 128,
    parameter int FRAME_WORDS = 41,
    parameter int ACC_CYCLES  = 4
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [AW-1:0] paddr,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    output logic          cfg_en,
    output logic          cfg_we,
    output logic [DW-1:0] cfg_wdata,
    input  logic [DW-1:0] cfg_rdata
);

    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = $clog2(DEPTH);

    logic             busy, done, push, pop, clr_ptr, clr_done, go_wr, go_rd;
    logic [CNT_W-1:0] len;
    logic [DW-1:0]    bus_rdata, pb_rdata, pb_wdata;
    logic [PTR_W-1:0] pb_addr;
    logic             pb_we;

    cfgbr_apb_dec #(
        .DW(DW), .AW(AW), .DEPTH(DEPTH), .FRAME(FRAME_WORDS), .ACC(ACC_CYCLES), .CNT_W(CNT_W)
    ) u_dec (
        .clk(clk), .rst_n(rst_n),
        .psel(psel), .penable(penable), .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata),
        .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .busy_i(busy), .done_i(done), .buf_rdata_i(bus_rdata),
        .push_o(push), .pop_o(pop), .clr_ptr_o(clr_ptr), .clr_done_o(clr_done),
        .go_wr_o(go_wr), .go_rd_o(go_rd), .len_o(len)
    );

    cfgbr_buf #(
        .DW(DW), .DEPTH(DEPTH), .PTR_W(PTR_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .push_i(push), .push_data_i(pwdata), .pop_i(pop),
        .clr_ptr_i(clr_ptr), .rewind_rd_i(go_rd), .busy_i(busy),
        .bus_rdata_o(bus_rdata),
        .pb_addr_i(pb_addr), .pb_we_i(pb_we), .pb_wdata_i(pb_wdata), .pb_rdata_o(pb_rdata)
    );

    cfgbr_portctl #(
        .DW(DW), .DEPTH(DEPTH), .FRAME(FRAME_WORDS), .ACC(ACC_CYCLES), .CNT_W(CNT_W), .PTR_W(PTR_W)
    ) u_port (
        .clk(clk), .rst_n(rst_n),
        .go_wr_i(go_wr), .go_rd_i(go_rd), .len_i(len), .clr_done_i(clr_done),
        .busy_o(busy), .done_o(done),
        .pb_addr_o(pb_addr), .pb_we_o(pb_we), .pb_wdata_o(pb_wdata), .pb_rdata_i(pb_rdata),
        .cfg_en_o(cfg_en), .cfg_we_o(cfg_we), .cfg_wdata_o(cfg_wdata), .cfg_rdata_i(cfg_rdata)
    );

endmodule

// File: tb/tb_cfgport_apb_bridge.sv
module tb_cfgport_apb_bridge;

    localparam int ACC = 4;
    localparam logic [3:0] A_CTRL = 4'h0, A_STAT = 4'h4, A_COUNT = 4'h8, A_DATA = 4'hC;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [3:0]  paddr = '0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr;
    logic        cfg_en, cfg_we;
    logic [31:0] cfg_wdata, cfg_rdata;

    int vectors = 0;
    int fails = 0;
    int rd_idx = 0;
    logic [31:0] got_q[$];

    always #2 clk = ~clk;

    function automatic logic [31:0] rb_word(int k);
        return 32'h5A00_0000 | 32'(k * 7 + 3);
    endfunction

    assign cfg_rdata = rb_word(rd_idx);

    cfgport_apb_bridge dut (
        .clk(clk), .rst_n(rst_n), .psel(psel), .penable(penable), .pwrite(pwrite),
        .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready), .pslverr(pslverr),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata)
    );

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // per-clock reference model: ready timing and port transaction shape
    int acc_n = 0;
    int run = 0;
    logic        prev_we = 1'b0;
    logic [31:0] prev_wd = '0;
    always @(negedge clk) begin
        if (rst_n) begin
            if (psel && penable) acc_n++; else acc_n = 0;
            chk(pready == (acc_n == ACC), "R2 pready timing", 32'(pready), 32'(acc_n == ACC));
            if (cfg_en) begin
                run++;
                if (run > 1)
                    chk(cfg_we == prev_we && cfg_wdata == prev_wd, "R6 stable beat", cfg_wdata, prev_wd);
                if (run == ACC && cfg_we) got_q.push_back(cfg_wdata);
                prev_we = cfg_we;
                prev_wd = cfg_wdata;
            end else if (run > 0) begin
                chk(run == ACC, "R6 beat length", 32'(run), 32'(ACC));
                if (!prev_we) rd_idx++;
                run = 0;
            end
        end
    end

    task automatic apb(input logic wr, input logic [3:0] a, input logic [31:0] d,
                       output logic [31:0] rd, output logic err);
        int n;
        @(posedge clk); #1;
        psel = 1'b1; penable = 1'b0; pwrite = wr; paddr = a; pwdata = d;
        @(posedge clk); #1;
        penable = 1'b1;
        n = 0;
        do begin
            @(negedge clk);
            n++;
        end while (!pready && n < 20);
        rd = prdata;
        err = pslverr;
        chk(n == ACC, "R2 access length", 32'(n), 32'(ACC));
        @(posedge clk); #1;
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic wr_reg(input logic [3:0] a, input logic [31:0] d, output logic err);
        logic [31:0] dummy;
        apb(1'b1, a, d, dummy, err);
    endtask

    task automatic rd_reg(input logic [3:0] a, output logic [31:0] v);
        logic e;
        apb(1'b0, a, 32'h0, v, e);
    endtask

    task automatic wait_idle();
        logic [31:0] s;
        for (int i = 0; i < 3000; i++) begin
            rd_reg(A_STAT, s);
            if (!s[0]) break;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL R1 watchdog expired actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

    initial begin
        logic [31:0] v;
        logic e;
        int n0;

        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        chk(pready == 1'b0, "R1 pready reset", 32'(pready), 0);
        chk(cfg_en == 1'b0, "R1 cfg_en reset", 32'(cfg_en), 0);
        rd_reg(A_STAT, v);  chk(v == 0, "R1 status reset", v, 0);
        rd_reg(A_COUNT, v); chk(v == 0, "R1 count reset", v, 0);

        // R4: write transfer of one frame
        wr_reg(A_COUNT, 41, e);
        rd_reg(A_COUNT, v); chk(v == 41, "R3 count register", v, 41);
        for (int k = 0; k < 41; k++) begin
            wr_reg(A_DATA, 32'hA000_0000 + 32'(k), e);
            chk(e == 1'b0, "R3 idle push no error", 32'(e), 0);
        end
        wr_reg(A_CTRL, 32'h1, e);
        rd_reg(A_STAT, v); chk(v[0] == 1'b1, "R4 busy after start", v, 1);
        wr_reg(A_DATA, 32'hDEAD_BEEF, e);
        chk(e == 1'b1, "R8 pslverr on busy push", 32'(e), 1);
        wr_reg(A_CTRL, 32'h2, e);   // R10: ignored while busy
        wait_idle();
        rd_reg(A_STAT, v); chk(v == 32'hA, "R9 status done+refused", v, 32'hA);
        chk(got_q.size() == 41, "R4 word count sent", 32'(got_q.size()), 41);
        for (int k = 0; k < 41 && k < got_q.size(); k++)
            chk(got_q[k] == 32'hA000_0000 + 32'(k), "R4 word order", got_q[k], 32'hA000_0000 + 32'(k));
        chk(rd_idx == 0, "R10 start while busy ignored", 32'(rd_idx), 0);

        // R8: refused push left pointer and data untouched
        got_q.delete();
        for (int k = 0; k < 41; k++) wr_reg(A_DATA, 32'hB000_0000 + 32'(k * 3), e);
        wr_reg(A_COUNT, 82, e);
        wr_reg(A_CTRL, 32'h1, e);
        wait_idle();
        chk(got_q.size() == 82, "R8 two-frame length", 32'(got_q.size()), 82);
        for (int k = 0; k < 82 && k < got_q.size(); k++) begin
            v = (k < 41) ? 32'hA000_0000 + 32'(k) : 32'hB000_0000 + 32'((k - 41) * 3);
            chk(got_q[k] == v, "R8 buffer intact", got_q[k], v);
        end

        // R9 clear flags, R7 rejected counts
        wr_reg(A_CTRL, 32'h8, e);
        rd_reg(A_STAT, v); chk(v == 0, "R9 flags cleared", v, 0);
        got_q.delete();
        n0 = rd_idx;
        wr_reg(A_COUNT, 40, e); wr_reg(A_CTRL, 32'h1, e);
        rd_reg(A_STAT, v); chk(v == 32'h4, "R7 count 40 rejected", v, 4);
        wr_reg(A_COUNT, 0, e); wr_reg(A_CTRL, 32'h2, e);
        rd_reg(A_STAT, v); chk(v == 32'h4, "R7 count 0 rejected", v, 4);
        wr_reg(A_COUNT, 164, e); wr_reg(A_CTRL, 32'h1, e);
        rd_reg(A_STAT, v); chk(v == 32'h4, "R7 count 164 rejected", v, 4);
        repeat (20) @(posedge clk);
        chk(got_q.size() == 0, "R7 no port writes", 32'(got_q.size()), 0);
        chk(rd_idx == n0, "R7 no port reads", 32'(rd_idx), 32'(n0));

        // R5 readback
        wr_reg(A_COUNT, 41, e); wr_reg(A_CTRL, 32'h2, e);
        rd_reg(A_STAT, v); chk(v == 32'h1, "R9 accepted start clears error", v, 1);
        wait_idle();
        rd_reg(A_STAT, v); chk(v == 32'h2, "R5 readback done", v, 2);
        chk(rd_idx == n0 + 41, "R5 port read count", 32'(rd_idx), 32'(n0 + 41));
        for (int k = 0; k < 41; k++) begin
            rd_reg(A_DATA, v);
            chk(v == rb_word(n0 + k), "R5 readback word", v, rb_word(n0 + k));
        end

        // R3 pointer clear, R10 write wins over readback
        n0 = rd_idx;
        got_q.delete();
        wr_reg(A_CTRL, 32'h4, e);
        for (int k = 0; k < 41; k++) wr_reg(A_DATA, 32'hC000_0000 ^ (32'(k) << 8), e);
        wr_reg(A_CTRL, 32'h3, e);
        wait_idle();
        chk(got_q.size() == 41, "R10 write wins length", 32'(got_q.size()), 41);
        for (int k = 0; k < 41 && k < got_q.size(); k++)
            chk(got_q[k] == (32'hC000_0000 ^ (32'(k) << 8)), "R3 pointer cleared", got_q[k],
                32'hC000_0000 ^ (32'(k) << 8));
        chk(rd_idx == n0, "R10 no readback", 32'(rd_idx), 32'(n0));

        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end

endmodule